// File: doc/BRIEF.md
# Infrared Pulse-Width Bit Receiver

This block turns an already demodulated infrared remote signal into data words by timing its pulses. A reference pulse from the system timer is divided down by a programmable ratio to make a sampling tick. The remote input is synchronised, and each of its falling edges realigns that divider. The length of every low stretch is counted in sampling ticks. When the input rises again, the low length decides whether the bit was a 0 or a 1.

Decoded bits are shifted into a 16-bit shift register, first bit towards the MSB. After sixteen bits the word is copied to a transfer register and a sticky completion flag is raised. This flag drives the interrupt output when it is enabled. A long low stretch, at least the programmed leader length, is taken as a frame leader and restarts word assembly. Software sees seven word registers through a simple bus. Writes take effect only as full words. Reads always return the full word, so any byte of it may be taken.

Top module: `irpw_receiver`

## Requirements
- R1: After reset, DIV (addr 0), CTRL (addr 1), STAT (addr 2), LEAD (addr 3), SHIFT (addr 5) and XFER (addr 6) read 0, CLKST (addr 4) reads 0x00FF and `irq_o` is low.
- R2: The divider counter advances on each `tick_i` pulse and wraps to 0 on the pulse that finds it equal to DIV, which makes a period of DIV+1 pulses. CLKST bits [7:0] return the bitwise complement of the counter.
- R3: A falling edge on `ir_i` clears the divider counter, so CLKST reads 0x00FF afterwards.
- R4: With CTRL bit 1 = 0 (short format), a low stretch of more than 4 sampling ticks decodes as 1, and one of 4 ticks or fewer decodes as 0.
- R5: With CTRL bit 1 = 1 (long format), the threshold is 8 sampling ticks: more than 8 decodes as 1, and 8 or fewer decodes as 0.
- R6: Bits enter SHIFT at bit 0 and move towards bit 15. On the sixteenth bit the whole word is copied to XFER and STAT bit 0 is set.
- R7: If LEAD is nonzero and a low stretch lasts at least LEAD ticks, it is a leader: no bit is taken, SHIFT clears and the bit count restarts.
- R8: `irq_o` is high exactly when STAT bit 0 and CTRL bit 0 are both 1. Writing a full word with bit 0 set to STAT clears the flag.
- R9: A write whose byte enables `reg_be` are not both 1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Reference timer pulse, one clock wide per count |
| ir_i | input | 1 | Demodulated remote signal, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables for the write; both must be set |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Receive-complete interrupt |

## Verification
A divider count that has drifted shows up at CLKST as soon as it is read. A missed realignment also shows up there, right after the falling edge. Either fault later misclassifies bits and corrupts the word in XFER. A wrong bit count or a missed leader is only visible once a word completes: XFER then holds a shifted pattern, or the flag is raised one bit early or late. For this reason the bench sends known 16-bit patterns and checks the exact word. A completion flag that is stuck or badly cleared shows on `irq_o` in the cycle after the clearing write.

// File: rtl/irpw_pkg.sv
// Package: shared widths and register word indices of the IR pulse-width receiver.
// Assumes a 16-bit register bus addressed by word index.
package irpw_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DIV   = 3'd0,
        A_CTRL  = 3'd1,
        A_STAT  = 3'd2,
        A_LEAD  = 3'd3,
        A_CLKST = 3'd4,
        A_SHIFT = 3'd5,
        A_XFER  = 3'd6
    } reg_addr_e;

    localparam int CTRL_IEN_BIT = 0;
    localparam int CTRL_FMT_BIT = 1;
    localparam int STAT_DONE_BIT = 0;
endpackage

// File: rtl/irpw_sync_edge.sv
// Module: two-flop synchroniser plus edge detector for the remote input.
// Assumes the line idles high; the flops reset to 1 so no edge appears at reset.
module irpw_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    logic s1_q, s2_q, prev_q;

    // Purpose: bring the input into the clock domain and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            s1_q   <= ir_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Purpose: single-cycle edge strobes from the synchronised level.
    always_comb begin
        lvl_o  = s2_q;
        fall_o = prev_q & ~s2_q;
        rise_o = ~prev_q & s2_q;
    end
endmodule

// File: rtl/irpw_divider.sv
// Module: sampling-tick divider. It counts reference pulses and emits a tick
// every DIV+1 pulses. A falling edge of the remote input realigns it to 0.
// Assumes tick_i is a one-clock strobe.
module irpw_divider #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             resync_i,
    input  logic [CNT_W-1:0] div_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             samp_o
);
    logic [CNT_W-1:0] cnt_q;

    // Purpose: the tick fires when a reference pulse finds the counter at the limit.
    always_comb begin
        samp_o = tick_i && (cnt_q == div_i) && !resync_i;
        cnt_o  = cnt_q;
    end

    // Purpose: advance, wrap or realign the division counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (resync_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (cnt_q == div_i) cnt_q <= '0;
            else                cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/irpw_decoder.sv
// Module: measures low stretches in sampling ticks, classifies them as bits
// or a leader, assembles words and hands completed words to a transfer register.
// Assumes bits start with a falling edge and end with the next rising edge.
module irpw_decoder #(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 8,
    parameter int THR_A  = 4,
    parameter int THR_B  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_i,
    input  logic              lvl_i,
    input  logic              fall_i,
    input  logic              rise_i,
    input  logic              fmt_i,
    input  logic [LEN_W-1:0]  lead_i,
    output logic [DATA_W-1:0] shift_o,
    output logic [DATA_W-1:0] xfer_o,
    output logic [$clog2(DATA_W)-1:0] bcnt_o,
    output logic              leader_o,
    output logic              word_done_o
);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
    localparam logic [BC_W-1:0]  LAST_BIT = BC_W'(DATA_W - 1);

    logic [LEN_W-1:0]  low_q;
    logic              armed_q;
    logic [DATA_W-1:0] sr_q, xfer_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [LEN_W-1:0]  thr;
    logic              bit_val, close_bit;
    logic [DATA_W-1:0] sr_next;

    // Purpose: pick the threshold and classify the stretch that is closing.
    always_comb begin
        thr         = fmt_i ? LEN_W'(THR_B) : LEN_W'(THR_A);
        bit_val     = (low_q > thr);
        close_bit   = rise_i && armed_q;
        leader_o    = close_bit && (lead_i != '0) && (low_q >= lead_i);
        word_done_o = close_bit && !leader_o && (bcnt_q == LAST_BIT);
        sr_next     = {sr_q[DATA_W-2:0], bit_val};
        shift_o     = sr_q;
        xfer_o      = xfer_q;
        bcnt_o      = bcnt_q;
    end

    // Purpose: low-stretch length counter, saturating, armed by a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= '0;
            armed_q <= 1'b0;
        end else if (fall_i) begin
            low_q   <= '0;
            armed_q <= 1'b1;
        end else if (rise_i) begin
            armed_q <= 1'b0;
        end else if (samp_i && !lvl_i && armed_q && low_q != LEN_MAX) begin
            low_q <= low_q + 1'b1;
        end
    end

    // Purpose: shift register, bit count and transfer register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            xfer_q <= '0;
            bcnt_q <= '0;
        end else if (leader_o) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (close_bit) begin
            sr_q <= sr_next;
            if (word_done_o) begin
                xfer_q <= sr_next;
                bcnt_q <= '0;
            end else begin
                bcnt_q <= bcnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/irpw_regs.sv
// Module: register file with full-word writes, a write-1-to-clear completion
// flag and a combinational read mux. Assumes writes complete in one cycle.
module irpw_regs
    import irpw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_be,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [DATA_W-1:0] shift_i,
    input  logic [DATA_W-1:0] xfer_i,
    input  logic              word_done_i,
    output logic [CNT_W-1:0]  div_o,
    output logic [LEN_W-1:0]  lead_o,
    output logic              fmt_o,
    output logic              done_o,
    output logic              irq_o
);
    logic [CNT_W-1:0] div_q;
    logic [LEN_W-1:0] lead_q;
    logic             ien_q, fmt_q, done_q;
    logic             wr_ok;

    // Purpose: only a write with both byte lanes enabled is accepted.
    always_comb wr_ok = reg_we && (reg_be == 2'b11);

    // Purpose: writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            lead_q <= '0;
            ien_q  <= 1'b0;
            fmt_q  <= 1'b0;
        end else if (wr_ok) begin
            case (reg_addr)
                A_DIV:  div_q  <= reg_wdata[CNT_W-1:0];
                A_LEAD: lead_q <= reg_wdata[LEN_W-1:0];
                A_CTRL: begin
                    ien_q <= reg_wdata[CTRL_IEN_BIT];
                    fmt_q <= reg_wdata[CTRL_FMT_BIT];
                end
                default: ;
            endcase
        end
    end

    // Purpose: sticky completion flag; setting wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (word_done_i)
            done_q <= 1'b1;
        else if (wr_ok && reg_addr == A_STAT && reg_wdata[STAT_DONE_BIT])
            done_q <= 1'b0;
    end

    // Purpose: read mux; the clock status returns the complemented counter.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DIV:   reg_rdata[CNT_W-1:0] = div_q;
            A_CTRL:  begin
                reg_rdata[CTRL_IEN_BIT] = ien_q;
                reg_rdata[CTRL_FMT_BIT] = fmt_q;
            end
            A_STAT:  reg_rdata[STAT_DONE_BIT] = done_q;
            A_LEAD:  reg_rdata[LEN_W-1:0] = lead_q;
            A_CLKST: reg_rdata[CNT_W-1:0] = ~cnt_i;
            A_SHIFT: reg_rdata = shift_i;
            A_XFER:  reg_rdata = xfer_i;
            default: reg_rdata = '0;
        endcase
    end

    // Purpose: drive configuration and interrupt outputs.
    always_comb begin
        div_o  = div_q;
        lead_o = lead_q;
        fmt_o  = fmt_q;
        done_o = done_q;
        irq_o  = done_q && ien_q;
    end
endmodule

// File: rtl/irpw_receiver.sv
// Module: top of the IR pulse-width receiver. It connects the input
// synchroniser, the sampling divider, the bit decoder and the register file.
// Assumes a demodulated, idle-high input and a one-clock reference pulse.
module irpw_receiver
    import irpw_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int LEN_W = 8,
    parameter int THR_A = 4,
    parameter int THR_B = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ir_i,
    input  logic              reg_we,
    input  logic [1:0]        reg_be,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    logic                      lvl, fall, rise, samp;
    logic [CNT_W-1:0]          div_q, clk_cnt;
    logic [LEN_W-1:0]          lead_q;
    logic                      fmt_q, done_q;
    logic [DATA_W-1:0]         shift_q, xfer_q;
    logic [$clog2(DATA_W)-1:0] bit_cnt;
    logic                      leader_hit, word_done;

    irpw_sync_edge u_sync (
        .clk(clk), .rst_n(rst_n), .ir_i(ir_i),
        .lvl_o(lvl), .fall_o(fall), .rise_o(rise)
    );

    irpw_divider #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .resync_i(fall),
        .div_i(div_q), .cnt_o(clk_cnt), .samp_o(samp)
    );

    irpw_decoder #(
        .DATA_W(DATA_W), .LEN_W(LEN_W), .THR_A(THR_A), .THR_B(THR_B)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .samp_i(samp), .lvl_i(lvl),
        .fall_i(fall), .rise_i(rise), .fmt_i(fmt_q), .lead_i(lead_q),
        .shift_o(shift_q), .xfer_o(xfer_q), .bcnt_o(bit_cnt),
        .leader_o(leader_hit), .word_done_o(word_done)
    );

    irpw_regs #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt_i(clk_cnt), .shift_i(shift_q), .xfer_i(xfer_q),
        .word_done_i(word_done), .div_o(div_q), .lead_o(lead_q),
        .fmt_o(fmt_q), .done_o(done_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/irpw_checker.sv
// Module: property checker for irpw_receiver, attached with bind.
// Assumes the signals named below exist inside the top module.
module irpw_checker
    import irpw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_we,
    input logic [1:0]                reg_be,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_wdata,
    input logic [CNT_W-1:0]          div_q,
    input logic [CNT_W-1:0]          clk_cnt,
    input logic                      samp,
    input logic                      fall,
    input logic                      word_done,
    input logic                      leader_hit,
    input logic [$clog2(DATA_W)-1:0] bit_cnt,
    input logic [DATA_W-1:0]         xfer_q,
    input logic                      done_q,
    input logic                      irq_o
);
    // R2
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp |=> (clk_cnt == '0));
    // R3
    resync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (clk_cnt == '0));
    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> done_q);
    // R6
    xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_done |=> $stable(xfer_q));
    // R7
    leader_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        leader_hit |=> (bit_cnt == '0));
    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_be == 2'b11 && reg_addr == A_STAT && reg_wdata[0] && !word_done)
        |=> !irq_o);
    // R9
    byte_write_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_be != 2'b11 && reg_addr == A_DIV) |=> $stable(div_q));
endmodule

bind irpw_receiver irpw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_be(reg_be),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .div_q(div_q),
    .clk_cnt(clk_cnt), .samp(samp), .fall(fall), .word_done(word_done),
    .leader_hit(leader_hit), .bit_cnt(bit_cnt), .xfer_q(xfer_q),
    .done_q(done_q), .irq_o(irq_o)
);

// File: tb/irpw_receiver_tb.sv
// Directed bench for irpw_receiver: one task per scenario, each checks itself.
module irpw_receiver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        ir_i = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_be = 2'b11;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    irpw_receiver u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ir_i(ir_i),
        .reg_we(reg_we), .reg_be(reg_be), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ir_i = 1'b1; tick_i = 1'b1; reg_we = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 2'b11;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // One bit: high for hi cycles, then low for lo cycles, then back high.
    task automatic send_bit(input int hi, input int lo);
        ir_i = 1'b1; cycles(hi);
        ir_i = 1'b0; cycles(lo);
        ir_i = 1'b1;
    endtask

    task automatic send_word(input logic [15:0] w, input int t);
        for (int i = 15; i >= 0; i--)
            send_bit(t, w[i] ? 3 * t : t);
        cycles(t);
    endtask

    task automatic send_word_b(input logic [15:0] w, input int t);
        for (int i = 15; i >= 0; i--)
            send_bit(2 * t, w[i] ? 6 * t : 2 * t);
        cycles(2 * t);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd(3'd0, d); check("R1 DIV", d, 16'h0000);
        rd(3'd1, d); check("R1 CTRL", d, 16'h0000);
        rd(3'd2, d); check("R1 STAT", d, 16'h0000);
        rd(3'd3, d); check("R1 LEAD", d, 16'h0000);
        rd(3'd4, d); check("R1 CLKST", d, 16'h00FF);
        rd(3'd5, d); check("R1 SHIFT", d, 16'h0000);
        rd(3'd6, d); check("R1 XFER", d, 16'h0000);
        check("R1 irq", {15'b0, irq_o}, 16'h0000);
    endtask

    task automatic t_divider();
        logic [15:0] d;
        do_reset();
        tick_i = 1'b0;
        wr(3'd0, 16'h0005, 2'b11);
        rd(3'd0, d); check("R2 DIV write", d, 16'h0005);
        tick_i = 1'b1; cycles(3); tick_i = 1'b0;
        rd(3'd4, d); check("R2 count 3 complement", d, 16'h00FC);
        tick_i = 1'b1; cycles(2); tick_i = 1'b0;
        rd(3'd4, d); check("R2 count 5 complement", d, 16'h00FA);
        tick_i = 1'b1; cycles(1); tick_i = 1'b0;
        rd(3'd4, d); check("R2 wrap after DIV+1", d, 16'h00FF);
        tick_i = 1'b1; cycles(2); tick_i = 1'b0;
        rd(3'd4, d); check("R3 before edge", d, 16'h00FD);
        ir_i = 1'b0; cycles(6);
        rd(3'd4, d); check("R3 resync on fall", d, 16'h00FF);
        ir_i = 1'b1; cycles(6);
        rd(3'd4, d); check("R3 rise leaves count", d, 16'h00FF);
    endtask

    task automatic t_fmt_a();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0003, 2'b11);
        send_word(16'hA5C3, 8);
        rd(3'd6, d); check("R4 short format word", d, 16'hA5C3);
        rd(3'd2, d); check("R6 done flag", d, 16'h0001);
        rd(3'd5, d); check("R6 shift holds word", d, 16'hA5C3);
        send_word(16'h0000, 8);
        rd(3'd6, d); check("R4 all zeros", d, 16'h0000);
        send_word(16'hFFFF, 8);
        rd(3'd6, d); check("R4 all ones", d, 16'hFFFF);
    endtask

    task automatic t_fmt_b();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0003, 2'b11);
        wr(3'd1, 16'h0002, 2'b11);
        // 3T low in this format is 6 ticks: a 1 only under the short threshold
        for (int i = 0; i < 16; i++) send_bit(16, (i % 2 == 0) ? 24 : 48);
        cycles(16);
        rd(3'd6, d); check("R5 long format threshold", d, 16'h5555);
        send_word_b(16'h3C69, 8);
        rd(3'd6, d); check("R5 long format word", d, 16'h3C69);
    endtask

    task automatic t_leader();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0003, 2'b11);
        wr(3'd3, 16'h0010, 2'b11);
        for (int i = 0; i < 5; i++) send_bit(8, 24);
        cycles(8);
        rd(3'd5, d); check("R7 partial bits", d, 16'h001F);
        send_bit(8, 80);
        cycles(8);
        rd(3'd5, d); check("R7 leader clears shift", d, 16'h0000);
        send_word(16'h1234, 8);
        rd(3'd6, d); check("R7 word after leader", d, 16'h1234);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0003, 2'b11);
        send_word(16'h00F0, 8);
        check("R8 irq disabled", {15'b0, irq_o}, 16'h0000);
        wr(3'd1, 16'h0001, 2'b11);
        cycles(1);
        check("R8 irq enabled", {15'b0, irq_o}, 16'h0001);
        wr(3'd2, 16'h0001, 2'b01);
        cycles(1);
        check("R9 byte write no clear", {15'b0, irq_o}, 16'h0001);
        wr(3'd2, 16'h0001, 2'b11);
        cycles(1);
        check("R8 cleared irq", {15'b0, irq_o}, 16'h0000);
        rd(3'd2, d); check("R8 cleared flag", d, 16'h0000);
    endtask

    task automatic t_bytewrite();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0022, 2'b11);
        wr(3'd0, 16'h0077, 2'b01);
        rd(3'd0, d); check("R9 DIV low byte", d, 16'h0022);
        wr(3'd0, 16'h0077, 2'b10);
        rd(3'd0, d); check("R9 DIV high byte", d, 16'h0022);
        wr(3'd3, 16'h0040, 2'b01);
        rd(3'd3, d); check("R9 LEAD byte", d, 16'h0000);
        wr(3'd1, 16'h0003, 2'b00);
        rd(3'd1, d); check("R9 CTRL no lanes", d, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        t_reset();
        t_divider();
        t_fmt_a();
        t_fmt_b();
        t_leader();
        t_irq();
        t_bytewrite();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule